// File: doc/BRIEF.md
# DRAM size-probe address mirror

This block stands in for the parts of a DRAM controller that boot firmware touches while it works out how much memory is fitted. Firmware programs the controller for the widest row addressing it supports. It then writes a pattern one row boundary above the memory base and checks whether that pattern shows up at the base. The block decodes the geometry fields of the control word and compares them with the memory size fixed by the `MEM_MIB` parameter. When the programmed rows are too wide, it redirects a 4 KiB window at the first out-of-range row boundary back onto the first 4 KiB of memory. The probe then sees the wrap-around that a real, smaller part would show.

The memory side runs through a combinational remap. Each address presented on `acc_addr` leaves on `mem_addr`, either unchanged or folded into the base page. A word-wide register port holds three banks of registers: common, controller and PHY. Writing the controller's init register raises the "init done" and "active" flags that firmware polls.

`MEM_MIB` must be a power of two from 256 to 2048. Any other value, a `MEM_BASE` that is not 4 KiB aligned, or fewer than seven registers per bank stops elaboration with an error.

Top module: `dram_probe_mirror`

## Requirements
- R1: A common-bank write at index 0 is decoded as follows. Configured rows are bus_wdata[7:4]+1 and bank bits are bus_wdata[2]+2. The page is 2^(bus_wdata[11:8]+3) bytes. The installed row count is log2(MEM_MIB)+3 for 256, 512 and 1024 MiB, and is unknown for 2048 MiB.
- R2: If the configured rows are at least 3 and MEM_MIB equals 2^(rows−3), that write disables the mirror from the next clock edge.
- R3: Otherwise, if the installed row count is known, the mirror is enabled from the next edge. Its base is MEM_BASE + 2^(installed rows + bank bits) × page bytes, taken modulo 2^ADDR_W.
- R4: A control write matching neither rule leaves the mirror enable and base unchanged. Any cycle without an accepted control write also leaves them unchanged.
- R5: After reset the mirror is disabled, so no address is redirected, including the preset window at MEM_BASE+1 MiB.
- R6: While the mirror is enabled and base ≤ acc_addr < base+4096, mem_addr equals MEM_BASE with acc_addr[11:0] in its low bits. In every other case mem_addr equals acc_addr, in the same cycle.
- R7: A word write to controller-bank index 0 stores the written value. On the same edge it sets bit 0 of controller-bank index 4 (PHY init done) and bit 0 of index 6 (controller active).
- R8: bus_addr[13:12] selects the bank: 0 common, 1 controller, 2 PHY. bus_addr[11:2] is the word index and bus_addr[1:0] is ignored. A read returns the last value written to that register, combinationally. A write takes effect at the clock edge.
- R9: Only accesses with bus_size = 2'b10 (32-bit) are accepted. Any other size reads zero, and writes of any other size change nothing, the mirror included.
- R10: A read at an index ≥ NREGS or in bank 3 returns zero. A write there is ignored.
- R11: Reset clears every register in all three banks to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code; 2'b10 = 32-bit |
| bus_addr | input | OFF_W+2 | Bank select in top two bits, byte offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| acc_addr | input | ADDR_W | Memory-side address before remap |
| mem_addr | output | ADDR_W | Memory-side address after remap |

## Verification
The assertions assume that the bus and memory-side inputs are known, non-X values whenever reset is released. They also assume that `MEM_BASE` plus any computed mirror offset stays inside the address space, so the window never straddles the top of memory. The stimulus therefore uses a base well below the top. Its control words give mirror offsets of at most a few MiB, and it drives only defined values on every input from the first edge. Narrow accesses, bank 3 and indices at and above `NREGS` are driven on purpose, so the checks on ignored accesses see real traffic.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  localparam int WORD_W       = 32;
  localparam int WIN_W        = 12;   // mirror window is 2^12 bytes
  localparam int PHY_STAT_IDX = 4;    // controller bank word holding init-done
  localparam int CTL_STAT_IDX = 6;    // controller bank word holding active
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [1:0] {
    RG_COMMON = 2'd0,
    RG_CTRL   = 2'd1,
    RG_PHY    = 2'd2,
    RG_NONE   = 2'd3
  } dpm_region_e;

  typedef struct packed {
    logic [4:0] rows;       // configured row bits, 1..16
    logic [1:0] banks;      // bank bits, 2..3
    logic [4:0] page_log2;  // log2 of page bytes, 3..18
  } dpm_geom_t;

  function automatic dpm_geom_t decode_geom(logic [3:0] rows_f, logic bank_f,
                                            logic [3:0] page_f);
    dpm_geom_t g;
    g.rows      = {1'b0, rows_f} + 5'd1;
    g.banks     = {1'b0, bank_f} + 2'd2;
    g.page_log2 = {1'b0, page_f} + 5'd3;
    return g;
  endfunction

  // installed row bits, 0 when the size gives no usable answer
  function automatic int unsigned known_rows(int unsigned mib);
    for (int i = 8; i < 11; i++) begin
      if (mib == (32'd1 << i)) return i + 3;
    end
    return 0;
  endfunction

  function automatic logic size_legal(int unsigned mib);
    for (int i = 8; i < 12; i++) begin
      if (mib == (32'd1 << i)) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic rows_fit(int unsigned mib, logic [4:0] rows);
    if (rows < 5'd3) return 1'b0;
    return mib == (32'd1 << (rows - 5'd3));
  endfunction

  function automatic logic [63:0] mirror_offset(int unsigned arows, dpm_geom_t g);
    int unsigned sh;
    sh = arows + int'(g.banks) + int'(g.page_log2);
    return 64'd1 << sh;
  endfunction

endpackage

// File: rtl/dpm_reg_bank.sv
module dpm_reg_bank #(
  parameter int NREGS     = 16,
  parameter int IDX_W     = 10,
  parameter bit INIT_SIDE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [dpm_pkg::WORD_W-1:0] wdata,
  output logic [dpm_pkg::WORD_W-1:0] rdata,
  output logic                       in_range
);
  import dpm_pkg::*;

  localparam int SW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [WORD_W-1:0] regs [NREGS];
  logic [SW-1:0]     slot;
  logic              init_pulse;

  assign slot     = idx[SW-1:0];
  assign in_range = (32'(idx) < NREGS);
  assign rdata    = in_range ? regs[slot] : '0;

  generate
    if (INIT_SIDE) begin : g_init
      assign init_pulse = wr_en && (idx == '0);

      // R7: init write raises both status flags on the following edge
      a_r7_init_flags: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (regs[PHY_STAT_IDX][0] && regs[CTL_STAT_IDX][0]));
    end else begin : g_plain
      assign init_pulse = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (init_pulse) begin
        regs[PHY_STAT_IDX][0] <= 1'b1;
        regs[CTL_STAT_IDX][0] <= 1'b1;
      end
      if (wr_en && in_range) regs[slot] <= wdata;
    end
  end

endmodule

// File: rtl/dpm_mirror_ctrl.sv
module dpm_mirror_ctrl #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'h4000_0000,
  parameter int unsigned       MEM_MIB  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_wr,
  input  logic [3:0]        rows_f,
  input  logic              bank_f,
  input  logic [3:0]        page_f,
  output logic              mir_en,
  output logic [ADDR_W-1:0] mir_base
);
  import dpm_pkg::*;

  localparam int unsigned ACT_ROWS = known_rows(MEM_MIB);
  localparam logic [ADDR_W-1:0] RESET_BASE = MEM_BASE + ADDR_W'(32'h0010_0000);

  dpm_geom_t         geom;
  logic              rule_off;
  logic              rule_on;
  logic [63:0]       off64;
  logic [ADDR_W-1:0] new_base;

  assign geom     = decode_geom(rows_f, bank_f, page_f);
  assign rule_off = rows_fit(MEM_MIB, geom.rows);
  assign rule_on  = !rule_off && (ACT_ROWS != 0);
  assign off64    = mirror_offset(ACT_ROWS, geom);
  assign new_base = MEM_BASE + off64[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir_en   <= 1'b0;
      mir_base <= RESET_BASE;
    end else if (cr_wr) begin
      if (rule_off) begin
        mir_en <= 1'b0;
      end else if (rule_on) begin
        mir_en   <= 1'b1;
        mir_base <= new_base;
      end
    end
  end

  // R2: matching rows turn the mirror off
  a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr && rule_off) |=> !mir_en);

  // R3: mismatched rows with known size turn it on at the computed base
  a_r3_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr && rule_on) |=> (mir_en && mir_base == $past(new_base)));

  // R4: no accepted control write, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_wr |=> ($stable(mir_en) && $stable(mir_base)));

endmodule

// File: rtl/dpm_remap.sv
module dpm_remap #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mir_en,
  input  logic [ADDR_W-1:0] mir_base,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] mem_addr
);
  import dpm_pkg::*;

  logic [ADDR_W-1:0] delta;
  logic              above;
  logic              hit;

  assign delta    = acc_addr - mir_base;
  assign above    = (acc_addr >= mir_base);
  assign hit      = mir_en && above && (delta[ADDR_W-1:WIN_W] == '0);
  assign mem_addr = hit ? (MEM_BASE | {{(ADDR_W-WIN_W){1'b0}}, acc_addr[WIN_W-1:0]})
                        : acc_addr;

  // R6: a disabled mirror is transparent
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_en |-> (mem_addr == acc_addr));

  // R6: a redirected access lands in the base page
  a_r6_base_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != acc_addr) |-> (mem_addr[ADDR_W-1:WIN_W] == MEM_BASE[ADDR_W-1:WIN_W]));

endmodule

// File: rtl/dram_probe_mirror.sv
module dram_probe_mirror #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_BASE = 32'h4000_0000,
  parameter int unsigned       MEM_MIB  = 256,
  parameter int                NREGS    = 16,
  parameter int                OFF_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [OFF_W+1:0]  bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] mem_addr
);
  import dpm_pkg::*;

  localparam int IDX_W  = OFF_W - 2;
  localparam int NBANKS = 3;

  generate
    if (!size_legal(MEM_MIB)) begin : g_bad_size
      $error("MEM_MIB must be a power of two between 256 and 2048");
    end
    if (MEM_BASE[WIN_W-1:0] != '0) begin : g_bad_base
      $error("MEM_BASE must be aligned to the mirror window");
    end
    if (NREGS <= CTL_STAT_IDX) begin : g_bad_nregs
      $error("NREGS too small for the status words");
    end
  endgenerate

  dpm_region_e        region;
  logic [IDX_W-1:0]   idx;
  logic               word_ok;
  logic               wr_any;
  logic               rd_go;
  logic [NBANKS-1:0]  wr_go;
  logic [NBANKS-1:0]  bank_ok;
  logic [31:0]        bank_rd [NBANKS];
  logic               cr_wr;
  logic               mir_en;
  logic [ADDR_W-1:0]  mir_base;
  logic               unused_lo;

  assign region    = dpm_region_e'(bus_addr[OFF_W+1:OFF_W]);
  assign idx       = bus_addr[OFF_W-1:2];
  assign unused_lo = ^bus_addr[1:0];
  assign word_ok   = (bus_size == SIZE_WORD);
  assign wr_any    = bus_valid && bus_write && word_ok;
  assign rd_go     = bus_valid && !bus_write && word_ok;

  generate
    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
      assign wr_go[g] = wr_any && (region == dpm_region_e'(g));
      dpm_reg_bank #(
        .NREGS    (NREGS),
        .IDX_W    (IDX_W),
        .INIT_SIDE(g == 1)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go[g]),
        .idx     (idx),
        .wdata   (bus_wdata),
        .rdata   (bank_rd[g]),
        .in_range(bank_ok[g])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      case (region)
        RG_COMMON: bus_rdata = bank_ok[0] ? bank_rd[0] : '0;
        RG_CTRL:   bus_rdata = bank_ok[1] ? bank_rd[1] : '0;
        RG_PHY:    bus_rdata = bank_ok[2] ? bank_rd[2] : '0;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign cr_wr = wr_go[0] && bank_ok[0] && (idx == '0);

  dpm_mirror_ctrl #(
    .ADDR_W  (ADDR_W),
    .MEM_BASE(MEM_BASE),
    .MEM_MIB (MEM_MIB)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cr_wr   (cr_wr),
    .rows_f  (bus_wdata[7:4]),
    .bank_f  (bus_wdata[2]),
    .page_f  (bus_wdata[11:8]),
    .mir_en  (mir_en),
    .mir_base(mir_base)
  );

  dpm_remap #(
    .ADDR_W  (ADDR_W),
    .MEM_BASE(MEM_BASE)
  ) u_remap (
    .clk     (clk),
    .rst_n   (rst_n),
    .mir_en  (mir_en),
    .mir_base(mir_base),
    .acc_addr(acc_addr),
    .mem_addr(mem_addr)
  );

  // R9: narrow reads return zero
  a_r9_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !word_ok) |-> (bus_rdata == '0));

  // R10: the unused bank reads as zero
  a_r10_bank3_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && region == RG_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/dram_probe_mirror_tb.sv
`timescale 1ns/1ps
module dram_probe_mirror_tb;

  localparam int          AW   = 32;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int          NR   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'b10;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic [31:0] rdata_s, rdata_b, mem_s, mem_b;

  always #10 clk = ~clk;

  dram_probe_mirror #(.ADDR_W(AW), .MEM_BASE(BASE), .MEM_MIB(256), .NREGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_s), .acc_addr(acc_addr), .mem_addr(mem_s));

  dram_probe_mirror #(.ADDR_W(AW), .MEM_BASE(BASE), .MEM_MIB(2048), .NREGS(NR)) u_dut_big (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_b), .acc_addr(acc_addr), .mem_addr(mem_b));

  // reference model state
  logic [31:0] mreg [3][NR];
  bit          men  [2];
  logic [31:0] mbase[2];
  int          mib_of [2] = '{256, 2048};

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic model_reset();
    for (int r = 0; r < 3; r++) for (int i = 0; i < NR; i++) mreg[r][i] = '0;
    for (int k = 0; k < 2; k++) begin
      men[k] = 1'b0;
      mbase[k] = BASE + 32'h0010_0000;
    end
  endtask

  function automatic int ref_rows(int mib);
    int v = mib;
    int n = 0;
    if (mib > 1024) return 0;
    while (v > 1) begin v = v / 2; n++; end
    return n + 3;
  endfunction

  function automatic logic [31:0] exp_map(int k, logic [31:0] a);
    if (men[k] && a >= mbase[k] && (a - mbase[k]) < 4096)
      return BASE + (a - mbase[k]);
    return a;
  endfunction

  function automatic logic [31:0] exp_read(bit v, bit w, logic [1:0] sz, logic [13:0] ad);
    int r = int'(ad[13:12]);
    int i = int'(ad[11:2]);
    if (v && !w && sz == 2'b10 && r < 3 && i < NR) return mreg[r][i];
    return 32'h0;
  endfunction

  task automatic model_write(logic [13:0] ad, logic [31:0] wd);
    int r = int'(ad[13:12]);
    int i = int'(ad[11:2]);
    if (r >= 3 || i >= NR) return;
    if (r == 1 && i == 0) begin
      mreg[1][4][0] = 1'b1;
      mreg[1][6][0] = 1'b1;
    end
    mreg[r][i] = wd;
    if (r == 0 && i == 0) begin
      for (int k = 0; k < 2; k++) begin
        int rows  = int'(wd[7:4]) + 1;
        int banks = int'(wd[2]) + 2;
        int plog  = int'(wd[11:8]) + 3;
        int arow  = ref_rows(mib_of[k]);
        longint unsigned span;
        if (rows >= 3 && mib_of[k] == (1 << (rows - 3))) begin
          men[k] = 1'b0;
        end else if (arow != 0) begin
          span = (64'd1 << (arow + banks)) * (64'd1 << plog);
          men[k] = 1'b1;
          mbase[k] = BASE + span[31:0];
        end
      end
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [1:0] sz, logic [13:0] ad,
                      logic [31:0] wd, logic [31:0] acc, string tag);
    logic [31:0] er;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_size = sz;
    bus_addr = ad; bus_wdata = wd; acc_addr = acc;
    #2;
    er = exp_read(v, w, sz, ad);
    check(tag, "rdata(256)", rdata_s, er);
    check(tag, "rdata(2048)", rdata_b, er);
    check(tag, "mem_addr(256)", mem_s, exp_map(0, acc));
    check(tag, "mem_addr(2048)", mem_b, exp_map(1, acc));
    @(posedge clk);
    #1;
    if (v && w && sz == 2'b10) model_write(ad, wd);
  endtask

  task automatic wr(logic [13:0] ad, logic [31:0] wd, string tag);
    step(1'b1, 1'b1, 2'b10, ad, wd, BASE, tag);
  endtask
  task automatic rd(logic [13:0] ad, string tag);
    step(1'b1, 1'b0, 2'b10, ad, 32'h0, BASE, tag);
  endtask
  task automatic probe(logic [31:0] a, string tag);
    step(1'b0, 1'b0, 2'b10, 14'h0, 32'h0, a, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R11: every register reads zero after reset
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < NR; i++)
        rd(14'((r << 12) | (i << 2)), "R11");

    // R5: nothing redirected, including the preset window
    probe(BASE + 32'h0010_0000, "R5");
    probe(BASE + 32'h0010_0008, "R5");
    probe(BASE + 32'h0001_0010, "R5");

    // R1 R3: rows 16, banks 2, page 8 -> base + 64 KiB on the 256 MiB part
    wr(14'h0000, 32'h0000_00F0, "R3");
    probe(BASE + 32'h0001_0010, "R6");
    probe(BASE + 32'h0001_0FFF, "R6");
    probe(BASE + 32'h0001_1000, "R6");
    probe(BASE + 32'h0000_FFFF, "R6");
    probe(BASE + 32'h0010_0000, "R4");   // 2048 MiB part stays off
    rd(14'h0000, "R8");

    // R2: rows 11 match 256 MiB
    wr(14'h0000, 32'h0000_02A4, "R2");
    probe(BASE + 32'h0001_0010, "R2");

    // R1: rows 13, banks 3, page 32 -> 2^19 offset
    wr(14'h0000, 32'h0000_02C4, "R1");
    probe(BASE + 32'h0008_0123, "R1");
    probe(BASE + 32'h0001_0010, "R1");

    // R2 on the large part: rows 14 match 2048 MiB; small part re-bases
    wr(14'h0000, 32'h0000_00D0, "R2");
    probe(BASE + 32'h0001_0ABC, "R3");

    // R1: rows field 0 gives one row bit, never the disable rule
    wr(14'h0000, 32'h0000_0504, "R1");
    probe(BASE + 32'h0040_0020, "R3");

    // R4: other writes leave the mirror alone
    wr(14'h0004, 32'h1234_5678, "R4");
    probe(BASE + 32'h0040_0020, "R4");
    wr(14'h2000, 32'h0000_02A4, "R4");
    probe(BASE + 32'h0040_0FF0, "R4");

    // R9: narrow accesses
    step(1'b1, 1'b1, 2'b01, 14'h0000, 32'h0000_02A4, BASE, "R9");
    probe(BASE + 32'h0040_0020, "R9");
    step(1'b1, 1'b0, 2'b01, 14'h0000, 32'h0, BASE, "R9");
    step(1'b1, 1'b0, 2'b00, 14'h0004, 32'h0, BASE, "R9");
    rd(14'h0000, "R9");

    // R10: out-of-range accesses
    wr(14'h3000, 32'hDEAD_BEEF, "R10");
    rd(14'h3000, "R10");
    wr(14'(NR << 2), 32'hCAFE_0001, "R10");
    rd(14'(NR << 2), "R10");
    rd(14'((NR - 1) << 2), "R10");

    // R7: PHY init handshake
    wr(14'h1000, 32'h0000_005A, "R7");
    rd(14'h1010, "R7");
    rd(14'h1018, "R7");
    rd(14'h1000, "R7");

    // R8: direct writes, bank select, ignored low address bits
    wr(14'h1010, 32'h0000_00F0, "R8");
    rd(14'h1010, "R8");
    wr(14'h2008, 32'hA5A5_0F0F, "R8");
    rd(14'h2009, "R8");
    rd(14'h0008, "R8");

    // R6: sweep across the current window
    for (int i = 0; i < 16; i++)
      probe(BASE + 32'h0040_0000 - 32'd600 + 32'(i * 300), "R6");

    // R11: reset again after traffic
    do_reset();
    rd(14'h0000, "R11");
    rd(14'h1018, "R11");
    rd(14'h2008, "R11");
    probe(BASE + 32'h0040_0020, "R5");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule